// File: doc/BRIEF.md
# AUX Request Header Packer

This block turns one request descriptor into the byte stream of a DisplayPort AUX request and then parses the reply that comes back. A descriptor carries a 4-bit request code, a 20-bit address, a payload length, up to 16 payload bytes and the size of the caller's receive buffer. The block checks the descriptor against the read and write payload limits, then sends a 4-byte header followed by any write payload on a valid/ready byte stream.

After the last transmitted byte, the block takes reply bytes on a simple valid/last stream. The first reply byte is the status and the rest are data. When the final reply byte arrives, the block presents one result for a single cycle. The result holds the reply code, an error class, a byte count and the received data, clipped to the caller's buffer. The line coding, timers and retry policy belong to the surrounding logic.

Top module: `aux_req_packer`

## Requirements
- R1: Header byte 0 is address[7:0]. Byte 1 is address[15:8]. Byte 2 holds the request code in bits 7:4 and address[19:16] in bits 3:0.
- R2: The low nibble of header byte 3 is the payload length minus one, or 0 when the length is 0.
- R3: The high nibble of header byte 3 is the transmitted byte count modulo 16. That count is 4 plus the length for writes and 4 for reads. A zero-length request uses 3 instead, but all four header bytes are still sent.
- R4: A write sends its payload bytes right after the header, starting with byte 0 (req_data[7:0]). A read sends only the header. tx_last marks the final byte and tx_valid is low outside the send phase.
- R5: A write longer than 12 bytes or a read longer than 16 bytes is refused. The refusal is a one-cycle req_reject pulse in the cycle after acceptance, and no byte is sent.
- R6: Requests are classified after bit 2 of the code (the I2C middle-of-transaction bit) is cleared. Codes 8, 0 and 2 are writes and codes 9 and 1 are reads; any other code is refused like R5. The header carries the code unchanged.
- R7: done_code is the reply status byte shifted right by 4.
- R8: A status byte equal to 1, 2 or 3 gives done_err 1 (timeout), 2 (flags not zero) or 3 (generic error), with done_count 0 and done_data all zero. Any other status gives done_err 0.
- R9: For a successful read, done_count is the smallest of the number of reply data bytes, the buffer size and 16. Reply byte k lands in done_data[8k+7:8k], and the bytes above the count are zero.
- R10: For a successful write, done_count equals the payload length and done_data is zero.
- R11: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last hold their values.
- R12: done_valid is high for exactly one cycle, the cycle after the reply byte with rx_last is taken. req_ready is high only while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Block idle, descriptor taken on valid |
| req_code | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Payload length in bytes |
| req_data | input | 128 | Write payload, byte i at bits 8i+7:8i |
| req_buf_size | input | 5 | Caller receive buffer size in bytes |
| req_reject | output | 1 | Descriptor refused (one-cycle pulse) |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte taken |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final transmit byte |
| rx_valid | input | 1 | Reply byte valid |
| rx_data | input | 8 | Reply byte (status first) |
| rx_last | input | 1 | Final reply byte |
| done_valid | output | 1 | Result valid (one cycle) |
| done_code | output | 4 | Reply code |
| done_err | output | 2 | Error class |
| done_count | output | 5 | Bytes returned |
| done_data | output | 128 | Reply data, byte k at bits 8k+7:8k |

## Verification
A refusal shows on req_reject one clock after the accepting edge. The first header byte is valid on the same clock, and each later byte moves forward one clock after a handshake. The result appears one clock after the edge that takes the rx_last byte and is gone one clock later. The bench drives inputs and checks outputs on falling edges, so each check falls midway between the edge that produces a value and the next one. The reference model keeps the expected transmit bytes in a queue and pops a byte only on cycles where it drove tx_ready high. A stalled cycle is therefore checked against the same byte, and every cycle of the send and reply phases is compared.

// File: rtl/aux_pkt_pkg.sv
package aux_pkt_pkg;

  localparam int LEN_W = 5;

  typedef enum logic [1:0] {PK_IDLE, PK_SEND, PK_WAIT, PK_DONE} pk_state_e;
  typedef enum logic [1:0] {RK_BAD, RK_WRITE, RK_READ} req_kind_e;

  localparam logic [3:0] MOT_MASK = 4'b0100;

  // Read/write decision ignores the middle-of-transaction bit.
  function automatic req_kind_e classify(input logic [3:0] code);
    logic [3:0] base;
    base = code & ~MOT_MASK;
    case (base)
      4'h8, 4'h0, 4'h2: return RK_WRITE;
      4'h9, 4'h1:       return RK_READ;
      default:          return RK_BAD;
    endcase
  endfunction

  // Count byte: high nibble transmitted total (3 when bare), low nibble len-1.
  function automatic logic [7:0] count_byte(input logic [LEN_W-1:0] len,
                                            input logic is_wr);
    logic [3:0] lo;
    logic [3:0] hi;
    logic [LEN_W-1:0] tot;
    lo  = (len == '0) ? 4'h0 : 4'(len - LEN_W'(1));
    tot = is_wr ? LEN_W'(len + LEN_W'(4)) : LEN_W'(4);
    hi  = (len == '0) ? 4'h3 : tot[3:0];
    return {hi, lo};
  endfunction

  // Header as four bytes, byte 0 in bits 7:0.
  function automatic logic [31:0] pack_header(input logic [3:0] code,
                                              input logic [19:0] addr,
                                              input logic [LEN_W-1:0] len,
                                              input logic is_wr);
    return {count_byte(len, is_wr), code, addr[19:16], addr[15:8], addr[7:0]};
  endfunction

  function automatic logic [1:0] err_class(input logic [7:0] st);
    case (st)
      8'h01:   return 2'd1;
      8'h02:   return 2'd2;
      8'h03:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/aux_req_check.sv
module aux_req_check
  import aux_pkt_pkg::*;
#(
  parameter int MAX_RD = 16,
  parameter int MAX_WR = 12
) (
  input  logic [3:0]       code,
  input  logic [LEN_W-1:0] len,
  output logic             ok,
  output logic             is_wr
);
  localparam logic [LEN_W:0] RD_LIM = (LEN_W+1)'(MAX_RD);
  localparam logic [LEN_W:0] WR_LIM = (LEN_W+1)'(MAX_WR);

  req_kind_e kind;

  always_comb begin
    kind  = classify(code);
    is_wr = (kind == RK_WRITE);
    case (kind)
      RK_WRITE: ok = ({1'b0, len} <= WR_LIM);
      RK_READ:  ok = ({1'b0, len} <= RD_LIM);
      default:  ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/aux_tx_seq.sv
module aux_tx_seq
  import aux_pkt_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      ld_hdr,
  input  logic [LEN_W-1:0] ld_len,
  input  logic             ld_wr,
  input  logic [NB*8-1:0]  ld_pay,
  input  logic             active,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  output logic             tx_fin
);
  localparam int IW = $clog2(NB + 5);
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  logic [IW-1:0] idx_q;
  logic [IW-1:0] total_q;
  logic [31:0]   hdr_q;
  logic [7:0]    pay_q [NB];
  logic [PW-1:0] pidx;
  logic          in_hdr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      total_q <= '0;
      hdr_q   <= '0;
    end else if (load) begin
      idx_q   <= '0;
      hdr_q   <= ld_hdr;
      total_q <= ld_wr ? IW'(ld_len) + IW'(4) : IW'(4);
    end else if (tx_valid && tx_ready) begin
      idx_q   <= idx_q + IW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (!rst_n)    pay_q[i] <= '0;
      else if (load) pay_q[i] <= ld_pay[i*8 +: 8];
    end
  end

  always_comb begin
    in_hdr   = (idx_q < IW'(4));
    pidx     = PW'(idx_q - IW'(4));
    tx_valid = active;
    tx_data  = in_hdr ? hdr_q[{idx_q[1:0], 3'b000} +: 8] : pay_q[pidx];
    tx_last  = active && (idx_q == total_q - IW'(1));
    tx_fin   = tx_valid && tx_ready && tx_last;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (idx_q < total_q)); // R4

endmodule

// File: rtl/aux_rx_collect.sv
module aux_rx_collect
  import aux_pkt_pkg::*;
#(
  parameter int NB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic [LEN_W-1:0] buf_size,
  output logic [7:0]       status,
  output logic [NB*8-1:0]  data_flat,
  output logic [LEN_W-1:0] kept,
  output logic             fin
);
  localparam int PW = (NB > 1) ? $clog2(NB) : 1;

  logic             got_q;
  logic [7:0]       status_q;
  logic [7:0]       dat_q [NB];
  logic [LEN_W-1:0] kept_q;
  logic             take;
  logic             room;
  logic             store;

  always_comb begin
    take  = active && rx_valid;
    room  = (kept_q < buf_size) && (kept_q < LEN_W'(NB));
    store = take && got_q && room;
    fin   = take && rx_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      got_q    <= 1'b0;
      status_q <= '0;
      kept_q   <= '0;
    end else if (take) begin
      if (!got_q) begin
        status_q <= rx_data;
        got_q    <= 1'b1;
      end else if (room) begin
        kept_q   <= kept_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++) begin
      if (!rst_n || clear)
        dat_q[i] <= '0;
      else if (store && (kept_q[PW-1:0] == PW'(i)))
        dat_q[i] <= rx_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NB; g++) begin : g_flat
      assign data_flat[g*8 +: 8] = dat_q[g];
    end
  endgenerate

  assign status = status_q;
  assign kept   = kept_q;

  AST_KEEP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (kept_q <= buf_size) && (kept_q <= LEN_W'(NB))); // R9

endmodule

// File: rtl/aux_req_packer.sv
module aux_req_packer
  import aux_pkt_pkg::*;
#(
  parameter int NB     = 16,
  parameter int MAX_WR = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [3:0]       req_code,
  input  logic [19:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [NB*8-1:0]  req_data,
  input  logic [LEN_W-1:0] req_buf_size,
  output logic             req_reject,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             done_valid,
  output logic [3:0]       done_code,
  output logic [1:0]       done_err,
  output logic [LEN_W-1:0] done_count,
  output logic [NB*8-1:0]  done_data
);
  pk_state_e        state_q;
  logic             acc;
  logic             ok;
  logic             is_wr;
  logic             load;
  logic             wr_q;
  logic             rej_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] buf_q;
  logic             tx_fin;
  logic             rx_fin;
  logic [7:0]       status;
  logic [NB*8-1:0]  rx_flat;
  logic [LEN_W-1:0] kept;
  logic [31:0]      hdr;

  aux_req_check #(.MAX_RD(NB), .MAX_WR(MAX_WR)) u_chk (
    .code (req_code),
    .len  (req_len),
    .ok   (ok),
    .is_wr(is_wr)
  );

  always_comb begin
    req_ready = (state_q == PK_IDLE);
    acc       = req_valid && req_ready;
    load      = acc && ok;
    hdr       = pack_header(req_code, req_addr, req_len, is_wr);
  end

  aux_tx_seq #(.NB(NB)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .ld_hdr  (hdr),
    .ld_len  (req_len),
    .ld_wr   (is_wr),
    .ld_pay  (req_data),
    .active  (state_q == PK_SEND),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .tx_last (tx_last),
    .tx_fin  (tx_fin)
  );

  aux_rx_collect #(.NB(NB)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .active   (state_q == PK_WAIT),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .buf_size (buf_q),
    .status   (status),
    .data_flat(rx_flat),
    .kept     (kept),
    .fin      (rx_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PK_IDLE;
      wr_q    <= 1'b0;
      rej_q   <= 1'b0;
      len_q   <= '0;
      buf_q   <= '0;
    end else begin
      rej_q <= acc && !ok;
      case (state_q)
        PK_IDLE: if (load) begin
          state_q <= PK_SEND;
          wr_q    <= is_wr;
          len_q   <= req_len;
          buf_q   <= req_buf_size;
        end
        PK_SEND: if (tx_fin) state_q <= PK_WAIT;
        PK_WAIT: if (rx_fin) state_q <= PK_DONE;
        default: state_q <= PK_IDLE;
      endcase
    end
  end

  always_comb begin
    req_reject = rej_q;
    done_valid = (state_q == PK_DONE);
    done_code  = status[7:4];
    done_err   = err_class(status);
    if (done_err != 2'd0) begin
      done_count = '0;
      done_data  = '0;
    end else if (wr_q) begin
      done_count = len_q;
      done_data  = '0;
    end else begin
      done_count = kept;
      done_data  = rx_flat;
    end
  end

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (req_ready && !tx_valid)); // R5
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R12
  AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_err != 2'd0) |-> (done_count == '0 && done_data == '0)); // R8
  AST_READ_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !wr_q) |-> (done_count <= buf_q)); // R9
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!tx_valid && !done_valid)); // R12

endmodule

// File: tb/sim_aux_req_packer.sv
`timescale 1ns/1ps
module sim_aux_req_packer;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [3:0]   req_code = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_data = '0;
  logic [4:0]   req_buf_size = '0;
  logic         req_reject;
  logic         tx_valid;
  logic         tx_ready = 1'b0;
  logic [7:0]   tx_data;
  logic         tx_last;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_data = '0;
  logic         rx_last = 1'b0;
  logic         done_valid;
  logic [3:0]   done_code;
  logic [1:0]   done_err;
  logic [4:0]   done_count;
  logic [127:0] done_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  aux_req_packer u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act %0d exp below 100000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", r, act, exp);
    end
  endtask

  task automatic chk_v(input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", r, act, exp);
    end
  endtask

  function automatic int pbyte(input int a, input int i);
    return (a + 3 * i + 1) % 256;
  endfunction

  function automatic int rbyte(input int i);
    return (160 ^ (i * 7)) % 256;
  endfunction

  task automatic run_req(input logic [3:0] code, input int addr, input int len,
                         input int bsz, input int st, input int nrep, input bit stall);
    int mc, lo, hi, pos, n, err, cnt, lim;
    bit wr, rd, rej;
    int q[$];
    logic [127:0] expd;
    mc  = int'(code) & 11;
    wr  = (mc == 8) || (mc == 0) || (mc == 2);
    rd  = (mc == 9) || (mc == 1);
    rej = !(wr || rd) || (len > 16) || (wr && len > 12);

    @(negedge clk);
    req_code = code;
    req_addr = addr[19:0];
    req_len = len[4:0];
    req_buf_size = bsz[4:0];
    for (int i = 0; i < 16; i++) req_data[i*8 +: 8] = pbyte(addr, i)[7:0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (!(wr || rd)) chk("R6 reject unsupported code", int'(req_reject), 1);
    else chk("R5 reject pulse", int'(req_reject), int'(rej));
    if (rej) begin
      chk("R5 no byte on reject", int'(tx_valid), 0);
      @(negedge clk);
      chk("R5 reject one cycle", int'(req_reject), 0);
      chk("R5 still idle", int'(req_ready), 1);
      chk("R5 no byte later", int'(tx_valid), 0);
      return;
    end

    q.push_back(addr % 256);
    q.push_back((addr / 256) % 256);
    q.push_back(int'(code) * 16 + (addr / 65536) % 16);
    lo = (len == 0) ? 0 : len - 1;
    hi = (len == 0) ? 3 : (wr ? (len + 4) % 16 : 4);
    q.push_back(hi * 16 + lo);
    if (wr) for (int i = 0; i < len; i++) q.push_back(pbyte(addr, i));

    pos = 0;
    n = 0;
    while (q.size() > 0) begin
      tx_ready = !(stall && (n % 3 == 1));
      chk("R4 tx_valid in send", int'(tx_valid), 1);
      if (pos < 2) chk("R1 header addr byte", int'(tx_data), q[0]);
      else if (pos == 2) chk(code[2] ? "R6 code sent unchanged" : "R1 code byte", int'(tx_data), q[0]);
      else if (pos == 3) chk("R2 R3 count byte", int'(tx_data), q[0]);
      else chk("R4 payload byte", int'(tx_data), q[0]);
      chk("R4 tx_last", int'(tx_last), int'(q.size() == 1));
      if (!tx_ready) chk("R11 hold while stalled", int'(tx_valid), 1);
      if (tx_ready) begin
        q.pop_front();
        pos++;
      end
      n++;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R4 tx idle after last", int'(tx_valid), 0);

    for (int i = 0; i <= nrep; i++) begin
      rx_valid = 1'b1;
      rx_data = (i == 0) ? st[7:0] : rbyte(i - 1)[7:0];
      rx_last = (i == nrep);
      chk("R12 no result before last", int'(done_valid), 0);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_last = 1'b0;

    err = (st == 1) ? 1 : (st == 2) ? 2 : (st == 3) ? 3 : 0;
    lim = (bsz < 16) ? bsz : 16;
    cnt = (err != 0) ? 0 : wr ? len : ((nrep < lim) ? nrep : lim);
    expd = '0;
    if (err == 0 && !wr) for (int j = 0; j < cnt; j++) expd[j*8 +: 8] = rbyte(j)[7:0];

    chk("R12 result valid", int'(done_valid), 1);
    chk("R7 reply code", int'(done_code), st / 16);
    chk("R8 error class", int'(done_err), err);
    if (err != 0) chk("R8 count on error", int'(done_count), 0);
    else if (wr) chk("R10 write count", int'(done_count), cnt);
    else chk("R9 read count clipped", int'(done_count), cnt);
    if (err != 0) chk_v("R8 data on error", done_data, expd);
    else if (wr) chk_v("R10 write data zero", done_data, expd);
    else chk_v("R9 read data", done_data, expd);
    @(negedge clk);
    chk("R12 result one cycle", int'(done_valid), 0);
    chk("R12 ready again", int'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R12 reset ready", int'(req_ready), 1);
    chk("R4 reset tx idle", int'(tx_valid), 0);
    chk("R12 reset no result", int'(done_valid), 0);
    chk("R5 reset no reject", int'(req_reject), 0);

    run_req(4'h9, 20'h12345, 16, 16, 8'h00, 16, 1'b0);
    run_req(4'h8, 20'hABCDE, 12, 0, 8'h00, 0, 1'b1);
    run_req(4'h4, 20'h00050, 1, 0, 8'h10, 0, 1'b0);
    run_req(4'h1, 20'h00050, 0, 0, 8'h00, 0, 1'b0);
    run_req(4'h9, 20'h00200, 8, 5, 8'h00, 10, 1'b1);
    run_req(4'h5, 20'h00051, 4, 31, 8'h00, 20, 1'b0);
    run_req(4'h2, 20'hF0001, 0, 0, 8'h00, 0, 1'b0);
    run_req(4'h8, 20'h00300, 5, 0, 8'h00, 0, 1'b1);
    run_req(4'h8, 20'h00300, 13, 0, 8'h00, 0, 1'b0);
    run_req(4'h9, 20'h00300, 17, 16, 8'h00, 0, 1'b0);
    run_req(4'h3, 20'h00300, 1, 16, 8'h00, 0, 1'b0);
    run_req(4'hA, 20'h00300, 1, 16, 8'h00, 0, 1'b0);
    run_req(4'h9, 20'h00400, 4, 16, 8'h01, 3, 1'b0);
    run_req(4'h9, 20'h00400, 4, 16, 8'h02, 3, 1'b0);
    run_req(4'h8, 20'h00400, 2, 0, 8'h03, 0, 1'b0);
    run_req(4'h9, 20'h00400, 4, 16, 8'h13, 2, 1'b0);
    run_req(4'h9, 20'h00400, 4, 16, 8'h20, 4, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule